// File: doc/BRIEF.md
# Bus Capture DMA Controller

This block samples 32-bit words from an internal monitor bus and moves them into system memory. Accepted samples enter a small FIFO. A write master then drains the FIFO one word at a time through a single-beat write handshake. That handshake holds its request, address and data until the memory side signals ready. Software drives the block through six 16-bit registers: control, buffer start address, buffer length, status, and two read-only views of the next write address and of the words still to move.

A run starts when software sets the capture enable bit. In one-shot mode the block stores the programmed number of words into consecutive word addresses, then clears the enable bit by itself. In circular mode it writes continuously around the programmed buffer and returns to the start address after the last word. This continues until software clears the enable bit. The active flag covers both capture and the memory drain. A sticky flag records any sample lost because the FIFO was full.

Top module: `bus_capture_dma`

## Requirements
- R1: After reset every register reads 0 and no memory write is requested.
- R2: The byte offsets are 0x00 control (bit 0 capture enable, bit 1 circular mode), 0x04 start address, 0x08 length, 0x0C status (bit 0 active, bit 1 overflow), 0x10 current address and 0x14 remaining count. The start address register holds byte address bits [15:2] in place and reads bits [1:0] as 0. The length field is 14 bits and holds the word count minus one. Writes to 0x10 and 0x14 are ignored.
- R3: Writing control with bit 0 set while the block is inactive sets enable and active, loads the current address from the start address, and loads the remaining count from the length. The same write while the block is active leaves enable unchanged.
- R4: In one-shot mode exactly length+1 words are stored. They are written in arrival order to the start address, the start address + 4, and onward. Enable then clears by itself.
- R5: A sample is taken in each cycle where the valid strobe and enable are both high. If the FIFO is full, the sample is dropped and status bit 1 sets.
- R6: After the last word of the buffer is written, the current address returns to the start address and the remaining count reloads to the length. In circular mode enable stays 1 and writing continues around the buffer.
- R7: Active stays 1 until enable is 0, the FIFO is empty and no memory write is pending. Then it returns to 0.
- R8: A pending memory write keeps its request, address and data unchanged until ready is sampled high. Address bits [1:0] are always 0.
- R9: The overflow flag stays set until software writes status with bit 1 set. Writing 0 to that bit leaves it set.
- R10: Writing 0 to enable stops capture at once. Words already accepted are still written to memory.
- R11: Writes to the start address or length while active do not alter the running transfer. They take effect at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 5 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational on reg_addr |
| cap_valid | input | 1 | Monitor bus sample strobe |
| cap_data | input | 32 | Monitor bus sample |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 16 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the pending write |

## Verification
A corrupted FIFO pointer or count shows up as wrong or repeated data words in the memory write log. It appears at the first write after the fault, or as a missing or spurious overflow flag while the FIFO fills. A wrong one-shot counter changes the number of memory writes and leaves enable set or clears it early. The run-length sweep detects this within one run. Errors in the address or remaining-count logic show as writes outside the buffer, or as a current address read back other than the start address after each complete pass. A broken drain condition leaves active stuck high, so the idle wait expires, or drops it while writes are still pending.

// File: rtl/capdma_pkg.sv
// Shared constants of the capture DMA: register byte offsets and widths.
package capdma_pkg;
    localparam int REG_W = 16;
    localparam int OFS_W = 5;
    localparam logic [OFS_W-1:0] OFS_CTRL  = 5'h00;
    localparam logic [OFS_W-1:0] OFS_BASE  = 5'h04;
    localparam logic [OFS_W-1:0] OFS_LEN   = 5'h08;
    localparam logic [OFS_W-1:0] OFS_STAT  = 5'h0C;
    localparam logic [OFS_W-1:0] OFS_CADDR = 5'h10;
    localparam logic [OFS_W-1:0] OFS_CLEN  = 5'h14;
endpackage

// File: rtl/capdma_fifo.sv
// Sample FIFO with show-ahead read.
// Assumes the owner never pushes when full and never pops when empty.
module capdma_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  store [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;

    assign rdata = store[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) store[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (push && !pop)      cnt <= cnt + 1'b1;
            else if (pop && !push) cnt <= cnt - 1'b1;
        end
    end

    a_r5_push_not_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r7_pop_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/capdma_wr_master.sv
// Single-beat memory write master: takes one FIFO word and holds
// request and data until ready. Assumes the address comes from the owner
// and changes only on beat_done.
module capdma_wr_master #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_rdata,
    output logic         fifo_pop,
    input  logic         mem_ready,
    output logic         mem_req,
    output logic [W-1:0] mem_wdata,
    output logic         beat_done
);
    assign fifo_pop  = !mem_req && !fifo_empty;
    assign beat_done = mem_req && mem_ready;

    // Load a word when idle, release the request once ready is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req   <= 1'b0;
            mem_wdata <= '0;
        end else if (fifo_pop) begin
            mem_req   <= 1'b1;
            mem_wdata <= fifo_rdata;
        end else if (beat_done) begin
            mem_req   <= 1'b0;
        end
    end

    a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_wdata));
endmodule

// File: rtl/bus_capture_dma.sv
// Capture DMA top: register file, capture gating, run sequencing and the
// address/remaining counters. Assumes reg_addr is stable while reg_we is
// high and that AW is at most the 16-bit register width.
module bus_capture_dma
    import capdma_pkg::*;
#(
    parameter int DW         = 32,
    parameter int AW         = 16,
    parameter int LW         = 14,
    parameter int FIFO_DEPTH = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OFS_W-1:0]     reg_addr,
    input  logic                 reg_we,
    input  logic [REG_W-1:0]     reg_wdata,
    output logic [REG_W-1:0]     reg_rdata,
    input  logic                 cap_valid,
    input  logic [DW-1:0]        cap_data,
    output logic                 mem_req,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic                 mem_ready
);
    localparam int WA = AW - 2;

    logic          en, circ, ovf, active;
    logic [WA-1:0] base_q, run_base, cur_word;
    logic [LW-1:0] len_q, run_len, rem, cap_left;
    logic          wr_ctrl, wr_stat, start, accept, push, drop, last_cap;
    logic          fifo_full, fifo_empty, fifo_pop, beat_done;
    logic [DW-1:0] fifo_rdata;

    assign wr_ctrl  = reg_we && (reg_addr == OFS_CTRL);
    assign wr_stat  = reg_we && (reg_addr == OFS_STAT);
    assign start    = wr_ctrl && reg_wdata[0] && !active;
    assign accept   = cap_valid && en;
    assign push     = accept && !fifo_full;
    assign drop     = accept && fifo_full;
    assign last_cap = push && !circ && (cap_left == '0);
    assign mem_addr = {cur_word, 2'b00};

    capdma_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(cap_data),
        .pop(fifo_pop), .rdata(fifo_rdata), .full(fifo_full), .empty(fifo_empty)
    );

    capdma_wr_master #(.W(DW)) u_wr (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
        .fifo_pop(fifo_pop), .mem_ready(mem_ready), .mem_req(mem_req),
        .mem_wdata(mem_wdata), .beat_done(beat_done)
    );

    // Software-written configuration: start address, length, mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            len_q  <= '0;
            circ   <= 1'b0;
        end else begin
            if (reg_we && reg_addr == OFS_BASE) base_q <= reg_wdata[AW-1:2];
            if (reg_we && reg_addr == OFS_LEN)  len_q  <= reg_wdata[LW-1:0];
            if (wr_ctrl)                        circ   <= reg_wdata[1];
        end
    end

    // Capture enable with one-shot self-clear and one-shot word counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            cap_left <= '0;
        end else begin
            if (start)                         en <= 1'b1;
            else if (wr_ctrl && !reg_wdata[0]) en <= 1'b0;
            else if (last_cap)                 en <= 1'b0;
            if (start)                         cap_left <= len_q;
            else if (push && cap_left != '0)   cap_left <= cap_left - 1'b1;
        end
    end

    // Active covers capture plus the drain of FIFO and pending write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  active <= 1'b0;
        else if (start)                              active <= 1'b1;
        else if (!en && fifo_empty && !mem_req)      active <= 1'b0;
    end

    // Next write address and remaining count, wrapping at buffer end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_base <= '0;
            run_len  <= '0;
            cur_word <= '0;
            rem      <= '0;
        end else if (start) begin
            run_base <= base_q;
            run_len  <= len_q;
            cur_word <= base_q;
            rem      <= len_q;
        end else if (beat_done) begin
            if (rem == '0) begin
                cur_word <= run_base;
                rem      <= run_len;
            end else begin
                cur_word <= cur_word + 1'b1;
                rem      <= rem - 1'b1;
            end
        end
    end

    // Sticky overflow flag, cleared by writing 1; a new drop wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ovf <= 1'b0;
        else if (drop)                       ovf <= 1'b1;
        else if (wr_stat && reg_wdata[1])    ovf <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        unique case (reg_addr)
            OFS_CTRL:  reg_rdata = {{(REG_W-2){1'b0}}, circ, en};
            OFS_BASE:  reg_rdata = REG_W'({base_q, 2'b00});
            OFS_LEN:   reg_rdata = REG_W'(len_q);
            OFS_STAT:  reg_rdata = {{(REG_W-2){1'b0}}, ovf, active};
            OFS_CADDR: reg_rdata = REG_W'({cur_word, 2'b00});
            OFS_CLEN:  reg_rdata = REG_W'(rem);
            default:   reg_rdata = '0;
        endcase
    end

    a_r7_enable_within_active: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> active);
    a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> $stable(mem_addr));
    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf && !(wr_stat && reg_wdata[1]) |=> ovf);
    a_r3_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> en && active);
endmodule

// File: tb/tb_bus_capture_dma.sv
module tb_bus_capture_dma;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_data = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ready = 1'b0;

    bus_capture_dma dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_valid(cap_valid),
        .cap_data(cap_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int hold_chk = 0, hold_fail = 0;
    bit wd_fail = 1'b0;
    int stall = 1;
    int phase = 0;
    int log_n = 0;
    logic [15:0] log_a [256];
    logic [31:0] log_d [256];
    bit prev_wait = 1'b0;
    logic [15:0] prev_a;
    logic [31:0] prev_d;

    // Memory model: ready pattern, R8 hold check, write log.
    always @(negedge clk) begin
        if (rst_n && prev_wait) begin
            hold_chk++;
            if (!(mem_req && mem_addr == prev_a && mem_wdata == prev_d)) begin
                hold_fail++;
                $display("FAIL R8 hold actual=%0h/%0h expected=%0h/%0h",
                         mem_addr, mem_wdata, prev_a, prev_d);
            end
        end
        phase++;
        mem_ready = (stall == 0) ? 1'b0 : ((phase % stall) == 0);
        prev_wait = mem_req && !mem_ready;
        prev_a = mem_addr;
        prev_d = mem_wdata;
        if (mem_req && mem_ready && log_n < 256) begin
            if (mem_addr[1:0] != 2'b00) begin
                hold_fail++;
                $display("FAIL R8 alignment actual=%0h expected=%0h", mem_addr[1:0], 0);
            end
            log_a[log_n] = mem_addr;
            log_d[log_n] = mem_wdata;
            log_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + hold_chk + (wd_fail ? 1 : 0),
                 n_fail + hold_fail + (wd_fail ? 1 : 0));
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic feed(input int n, input logic [31:0] first);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cap_valid = 1'b1;
            cap_data = first + 32'(i);
        end
        @(negedge clk);
        cap_valid = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int k = 0; k < 3000; k++) begin
            rd(5'h0C, s);
            if (s[0] == 1'b0) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_fail = 1'b1;
        $display("FAIL watchdog R7 actual=%0h expected=%0h", 1, 0);
        report();
        $finish;
    end

    initial begin
        logic [15:0] v;
        int first;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all registers and the memory request.
        for (int r = 0; r < 6; r++) begin
            rd(5'(r * 4), v);
            check(v == 16'h0, "R1 register reset", 32'(v), 0);
        end
        check(mem_req == 1'b0, "R1 no request", 32'(mem_req), 0);

        // R2: alignment, field width, read-only views.
        wr(5'h04, 16'h0103); rd(5'h04, v);
        check(v == 16'h0100, "R2 start address low bits", 32'(v), 32'h0100);
        wr(5'h08, 16'hFFFF); rd(5'h08, v);
        check(v == 16'h3FFF, "R2 length width", 32'(v), 32'h3FFF);
        wr(5'h10, 16'h1234); rd(5'h10, v);
        check(v == 16'h0, "R2 current address read-only", 32'(v), 0);
        wr(5'h14, 16'h0055); rd(5'h14, v);
        check(v == 16'h0, "R2 remaining read-only", 32'(v), 0);

        // R3/R4/R6/R7: one-shot sweep over length and memory stall.
        for (int L = 0; L < 5; L++) begin
            for (int s = 1; s < 4; s++) begin
                logic [15:0] base;
                logic [31:0] d0;
                base = 16'h0100 + 16'(L * 16'h40);
                d0 = 32'hA000_0000 + 32'(L * 256 + s * 16);
                stall = s;
                first = log_n;
                wr(5'h04, base);
                wr(5'h08, 16'(L));
                wr(5'h00, 16'h0001);
                rd(5'h0C, v);
                check(v == 16'h0001, "R3 active after start", 32'(v), 1);
                rd(5'h10, v);
                check(v == base, "R3 current address loaded", 32'(v), 32'(base));
                rd(5'h14, v);
                check(v == 16'(L), "R3 remaining loaded", 32'(v), 32'(L));
                feed(L + 3, d0);
                wait_idle();
                check(log_n - first == L + 1, "R4 word count", 32'(log_n - first), 32'(L + 1));
                for (int i = 0; i <= L; i++) begin
                    check(log_a[first + i] == base + 16'(4 * i), "R4 address order",
                          32'(log_a[first + i]), 32'(base + 16'(4 * i)));
                    check(log_d[first + i] == d0 + 32'(i), "R4 data order",
                          log_d[first + i], d0 + 32'(i));
                end
                rd(5'h00, v);
                check(v == 16'h0, "R4 enable self-clears", 32'(v), 0);
                rd(5'h0C, v);
                check(v == 16'h0, "R7 inactive after drain", 32'(v), 0);
                rd(5'h10, v);
                check(v == base, "R6 address back at start", 32'(v), 32'(base));
                rd(5'h14, v);
                check(v == 16'(L), "R6 remaining reloaded", 32'(v), 32'(L));
            end
        end

        // R5/R9/R10: overflow with memory stalled, then software stop.
        stall = 0;
        first = log_n;
        wr(5'h04, 16'h0800);
        wr(5'h08, 16'd20);
        wr(5'h00, 16'h0001);
        feed(12, 32'h5000_0000);
        rd(5'h0C, v);
        check(v == 16'h0003, "R5 overflow and active", 32'(v), 3);
        rd(5'h00, v);
        check(v == 16'h0001, "R5 enable still set", 32'(v), 1);
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'h0001);
        rd(5'h00, v);
        check(v == 16'h0000, "R3 start ignored while active", 32'(v), 0);
        rd(5'h10, v);
        check(v == 16'h0800, "R3 address untouched while active", 32'(v), 32'h0800);
        wr(5'h0C, 16'h0000);
        rd(5'h0C, v);
        check(v == 16'h0003, "R9 write 0 keeps overflow", 32'(v), 3);
        stall = 1;
        wait_idle();
        check(log_n - first == 9, "R10 accepted words drained", 32'(log_n - first), 9);
        for (int i = 0; i < 9; i++) begin
            check(log_d[first + i] == 32'h5000_0000 + 32'(i), "R10 drained data",
                  log_d[first + i], 32'h5000_0000 + 32'(i));
            check(log_a[first + i] == 16'h0800 + 16'(4 * i), "R10 drained address",
                  32'(log_a[first + i]), 32'h0800 + 32'(4 * i));
        end
        rd(5'h0C, v);
        check(v == 16'h0002, "R9 overflow survives idle", 32'(v), 2);
        wr(5'h0C, 16'h0002);
        rd(5'h0C, v);
        check(v == 16'h0000, "R9 write 1 clears", 32'(v), 0);

        // R6/R11: circular wrap, reprogramming during the run.
        stall = 2;
        first = log_n;
        wr(5'h04, 16'h0200);
        wr(5'h08, 16'd2);
        wr(5'h00, 16'h0003);
        feed(4, 32'hC000_0000);
        wr(5'h04, 16'h0300);
        wr(5'h08, 16'd5);
        feed(5, 32'hC000_0004);
        rd(5'h00, v);
        check(v == 16'h0003, "R6 enable stays in circular mode", 32'(v), 3);
        wr(5'h00, 16'h0002);
        wait_idle();
        check(log_n - first == 9, "R6 circular word count", 32'(log_n - first), 9);
        for (int i = 0; i < 9; i++) begin
            check(log_a[first + i] == 16'h0200 + 16'(4 * (i % 3)), "R6 R11 wrap address",
                  32'(log_a[first + i]), 32'h0200 + 32'(4 * (i % 3)));
            check(log_d[first + i] == 32'hC000_0000 + 32'(i), "R6 circular data",
                  log_d[first + i], 32'hC000_0000 + 32'(i));
        end
        rd(5'h0C, v);
        check(v == 16'h0000, "R6 no overflow in circular run", 32'(v), 0);
        rd(5'h10, v);
        check(v == 16'h0200, "R6 address at start after full passes", 32'(v), 32'h0200);
        wr(5'h00, 16'h0001);
        rd(5'h10, v);
        check(v == 16'h0300, "R11 new start address applied", 32'(v), 32'h0300);
        rd(5'h14, v);
        check(v == 16'd5, "R11 new length applied", 32'(v), 5);
        wr(5'h00, 16'h0000);
        wait_idle();
        rd(5'h0C, v);
        check(v == 16'h0000, "R7 idle after empty run", 32'(v), 0);

        report();
        $finish;
    end
endmodule